// File: doc/BRIEF.md
# I2C Word-Oriented Slave Control Port

This block is the serial control port of a processor core that exchanges 32-bit words with an external host over a two-wire I2C bus. It samples SCL and SDA with the system clock, finds start and stop conditions, and compares the 7-bit address that follows a start with its own. On a match it either gathers write bytes from the host into whole words or sends read words back to it. Every transfer moves complete words of four bytes. Bytes and words go out most significant first.

On the core side there are two handshakes. A finished write word is offered on a valid/ready pair. A read word is requested with a request/acknowledge pair. While a handshake is pending the port pauses the bus in two ways at once. An active-low ready/busy pin goes low, and the port holds SCL low. A host can wait on either signal. When the core completes the handshake, both signals release and the host may send further words or end the transfer. The port drives the bus only through active-high output enables that pull a line low.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset and after every stop condition (SDA rising while SCL is high), sda_oe and scl_oe are low, busy_n is high, and wr_valid and rd_req are low.
- R2: The first byte after a start (SDA falling while SCL is high) is taken MSB first as a 7-bit address followed by a direction bit (1 = read). The port pulls SDA low on the ninth clock only if the address equals SLAVE_ADDR. On a mismatch it never pulls SDA low until the next start.
- R3: In a write, each byte is acknowledged, and four bytes are assembled MSB first into one word. The word appears on wr_data with wr_valid high after the fourth byte's acknowledge pulse.
- R4: While wr_valid is high, busy_n is low, scl_oe is high, and wr_data holds steady. All three release after the cycle in which wr_ready is high.
- R5: In a read, after the address acknowledge and after every fourth host-acknowledged byte, rd_req goes high with busy_n low and SCL held low until rd_ack. The word taken from rd_data is then shifted out MSB first.
- R6: The port changes sda_oe only while the synchronized SCL is low.
- R7: After the host answers a read byte with a NACK (SDA high on the ninth clock), the port drives no SDA and requests no word until the next start or stop.
- R8: A repeated start at any point restarts address matching. A partly received write word is discarded and never offered to the core.
- R9: After the acknowledge on the ninth clock, the port releases SDA once SCL falls.
- R10: One transfer may carry several words in either direction. Each word is handed over or fetched in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pulls SCL low when high (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low when high |
| busy_n | output | 1 | Low while the port is paused for the core |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Core accepts the write word |
| wr_data | output | 32 | Assembled write word |
| rd_req | output | 1 | Request for the next read word |
| rd_ack | input | 1 | Core supplies rd_data this cycle |
| rd_data | input | 32 | Read word from the core |

## Verification
A wrong bit or byte counter shows at the ports within one byte time. The acknowledge lands on the wrong clock, the host sees a NACK, or a word arrives on wr_data shifted or with bytes swapped. A state that enters or leaves the paused state wrongly shows as busy_n and scl_oe disagreeing with the core handshake in the same cycle. A host transaction can then hang until the watchdog fires, or a word is lost or repeated. A drive decision that is not tied to SCL low shows as sda_oe moving during a high clock phase, which would corrupt data or create a false start or stop.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

    localparam int BITS_PER_BYTE = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_WR_HOLD,
        ST_RD_FETCH,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } port_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.scl_pipe[0] = scl_i;
        sync_d.sda_pipe[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.scl_pipe[i] = sync_q.scl_pipe[i-1];
            sync_d.sda_pipe[i] = sync_q.sda_pipe[i-1];
        end
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_pipe[STAGES-1];
    assign sda_s     = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
    import i2c_word_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3C,
    parameter int         WORD_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sda_s,
    input  logic                          scl_rise,
    input  logic                          scl_fall,
    input  logic                          start_det,
    input  logic                          stop_det,
    input  logic                          wr_ready,
    input  logic                          rd_ack,
    input  logic [WORD_BYTES*8-1:0]       rd_data,
    output port_state_e                   state,
    output logic [WORD_BYTES*8-1:0]       word_out,
    output logic                          sda_oe,
    output logic                          scl_oe
);

    localparam int WORD_W   = WORD_BYTES * BITS_PER_BYTE;
    localparam int IDX_W    = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);
    localparam logic [3:0] FULL_BYTE = 4'(BITS_PER_BYTE);

    typedef struct packed {
        port_state_e         state;
        logic [3:0]          bit_cnt;
        logic [IDX_W-1:0]    byte_idx;
        logic [WORD_W-1:0]   shreg;
        logic                rw;
        logic                nack;
        logic                sda_oe;
        logic                scl_oe;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_ADDR: begin
                if (scl_rise && fsm_q.bit_cnt < FULL_BYTE) begin
                    fsm_d.shreg   = {fsm_q.shreg[WORD_W-2:0], sda_s};
                    fsm_d.bit_cnt = fsm_q.bit_cnt + 4'd1;
                end
                if (scl_fall && fsm_q.bit_cnt == FULL_BYTE) begin
                    fsm_d.rw = fsm_q.shreg[0];
                    if (fsm_q.shreg[7:1] == SLAVE_ADDR) begin
                        fsm_d.sda_oe = 1'b1;
                        fsm_d.state  = ST_ADDR_ACK;
                    end else begin
                        fsm_d.state  = ST_IGNORE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    fsm_d.sda_oe   = 1'b0;
                    fsm_d.bit_cnt  = '0;
                    fsm_d.byte_idx = '0;
                    if (fsm_q.rw) begin
                        fsm_d.scl_oe = 1'b1;
                        fsm_d.state  = ST_RD_FETCH;
                    end else begin
                        fsm_d.state  = ST_WR_BYTE;
                    end
                end
            end
            ST_WR_BYTE: begin
                if (scl_rise && fsm_q.bit_cnt < FULL_BYTE) begin
                    fsm_d.shreg   = {fsm_q.shreg[WORD_W-2:0], sda_s};
                    fsm_d.bit_cnt = fsm_q.bit_cnt + 4'd1;
                end
                if (scl_fall && fsm_q.bit_cnt == FULL_BYTE) begin
                    fsm_d.sda_oe = 1'b1;
                    fsm_d.state  = ST_WR_ACK;
                end
            end
            ST_WR_ACK: begin
                if (scl_fall) begin
                    fsm_d.sda_oe  = 1'b0;
                    fsm_d.bit_cnt = '0;
                    if (fsm_q.byte_idx == LAST_IDX) begin
                        fsm_d.scl_oe = 1'b1;
                        fsm_d.state  = ST_WR_HOLD;
                    end else begin
                        fsm_d.byte_idx = fsm_q.byte_idx + 1'b1;
                        fsm_d.state    = ST_WR_BYTE;
                    end
                end
            end
            ST_WR_HOLD: begin
                if (wr_ready) begin
                    fsm_d.scl_oe   = 1'b0;
                    fsm_d.byte_idx = '0;
                    fsm_d.bit_cnt  = '0;
                    fsm_d.state    = ST_WR_BYTE;
                end
            end
            ST_RD_FETCH: begin
                if (rd_ack) begin
                    fsm_d.shreg    = rd_data;
                    fsm_d.sda_oe   = ~rd_data[WORD_W-1];
                    fsm_d.scl_oe   = 1'b0;
                    fsm_d.bit_cnt  = '0;
                    fsm_d.byte_idx = '0;
                    fsm_d.state    = ST_RD_BYTE;
                end
            end
            ST_RD_BYTE: begin
                if (scl_rise) begin
                    fsm_d.bit_cnt = fsm_q.bit_cnt + 4'd1;
                end
                if (scl_fall) begin
                    fsm_d.shreg = {fsm_q.shreg[WORD_W-2:0], 1'b0};
                    if (fsm_q.bit_cnt == FULL_BYTE) begin
                        fsm_d.sda_oe = 1'b0;
                        fsm_d.nack   = 1'b0;
                        fsm_d.state  = ST_RD_ACK;
                    end else begin
                        fsm_d.sda_oe = ~fsm_q.shreg[WORD_W-2];
                    end
                end
            end
            ST_RD_ACK: begin
                if (scl_rise) begin
                    fsm_d.nack = sda_s;
                end
                if (scl_fall) begin
                    fsm_d.bit_cnt = '0;
                    if (fsm_q.nack) begin
                        fsm_d.state = ST_IGNORE;
                    end else if (fsm_q.byte_idx == LAST_IDX) begin
                        fsm_d.scl_oe = 1'b1;
                        fsm_d.state  = ST_RD_FETCH;
                    end else begin
                        fsm_d.byte_idx = fsm_q.byte_idx + 1'b1;
                        fsm_d.sda_oe   = ~fsm_q.shreg[WORD_W-1];
                        fsm_d.state    = ST_RD_BYTE;
                    end
                end
            end
            default: begin
            end
        endcase

        if (start_det) begin
            fsm_d.state   = ST_ADDR;
            fsm_d.bit_cnt = '0;
            fsm_d.sda_oe  = 1'b0;
            fsm_d.scl_oe  = 1'b0;
        end else if (stop_det) begin
            fsm_d.state   = ST_IDLE;
            fsm_d.bit_cnt = '0;
            fsm_d.sda_oe  = 1'b0;
            fsm_d.scl_oe  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, default: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state    = fsm_q.state;
    assign word_out = fsm_q.shreg;
    assign sda_oe   = fsm_q.sda_oe;
    assign scl_oe   = fsm_q.scl_oe;

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2c_word_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h3C,
    parameter int         WORD_BYTES  = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      scl_oe,
    output logic                      sda_oe,
    output logic                      busy_n,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [WORD_BYTES*8-1:0]   wr_data,
    output logic                      rd_req,
    input  logic                      rd_ack,
    input  logic [WORD_BYTES*8-1:0]   rd_data
);

    localparam int WORD_W = WORD_BYTES * BITS_PER_BYTE;

    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    port_state_e state;
    logic [WORD_W-1:0] word_out;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_word_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .WORD_BYTES(WORD_BYTES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wr_ready  (wr_ready),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .state     (state),
        .word_out  (word_out),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    assign wr_valid = (state == ST_WR_HOLD);
    assign rd_req   = (state == ST_RD_FETCH);
    assign busy_n   = ~(wr_valid | rd_req);
    assign wr_data  = word_out;

endmodule

// File: rtl/i2c_word_slave_chk.sv
module i2c_word_slave_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_req,
    input logic              rd_ack
);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !scl_oe && busy_n));

    assert_wr_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (!busy_n && scl_oe));

    assert_wr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

    assert_rd_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!busy_n && scl_oe));

    assert_rd_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    assert_sda_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

endmodule

bind i2c_word_slave i2c_word_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy_n   (busy_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack)
);

// File: tb/i2c_word_slave_test.sv
module i2c_word_slave_test;

    localparam logic [6:0] ADDR = 7'h3C;
    localparam int Q   = 8;
    localparam int LAT = 40;
    localparam int WATCHDOG = 150000;

    // {direction, address[6:0], word}
    localparam logic [39:0] VECS [0:5] = '{
        40'h3C_DEADBEEF,
        40'hBC_12345678,
        40'h3C_00000001,
        40'hBC_80FF007F,
        40'h11_A5A5A5A5,
        40'hBC_FFFFFFFF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe, busy_n, wr_valid, rd_req;
    logic wr_ready = 1'b0, rd_ack = 1'b0;
    logic [31:0] wr_data, rd_data;
    wire scl_line = ~(m_scl_low | scl_oe);
    wire sda_line = ~(m_sda_low | sda_oe);

    always #10 clk = ~clk;

    i2c_word_slave #(.SLAVE_ADDR(ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy_n(busy_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    int n_vec = 0, n_bad = 0;
    int ncap = 0, nfetch = 0, wcnt = 0, rcnt = 0;
    logic [31:0] cap [0:7];
    logic [31:0] rd_queue [0:7];
    int drive_cnt = 0, glitch = 0, hi_run = 0;
    logic sda_prev_b = 1'b0;
    logic stretched = 1'b0, stretch_busy = 1'b1;
    int cycles = 0;

    assign rd_data = rd_queue[nfetch % 8];

    // core model and line monitors
    always @(negedge clk) begin
        if (rst_n) begin
            wr_ready <= 1'b0;
            rd_ack   <= 1'b0;
            if (wr_valid && !wr_ready) begin
                if (wcnt == LAT) begin
                    wr_ready <= 1'b1;
                    cap[ncap % 8] <= wr_data;
                    ncap <= ncap + 1;
                    wcnt <= 0;
                end else wcnt <= wcnt + 1;
            end
            if (rd_req && !rd_ack) begin
                if (rcnt == LAT) begin
                    rd_ack <= 1'b1;
                    rcnt <= 0;
                end else rcnt <= rcnt + 1;
            end
            if (rd_ack) nfetch <= nfetch + 1;
            if (scl_line) hi_run <= hi_run + 1; else hi_run <= 0;
            if (hi_run >= 4 && sda_oe != sda_prev_b) glitch <= glitch + 1;
            sda_prev_b <= sda_oe;
            if (sda_oe) drive_cnt <= drive_cnt + 1;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise_scl();
        int waited = 0;
        m_scl_low = 1'b0;
        tick(1);
        while (!scl_line) begin
            waited++;
            if (waited == 20) begin
                stretched = 1'b1;
                stretch_busy = busy_n;
            end
            tick(1);
        end
    endtask

    task automatic send_bit(input logic b);
        tick(2);
        m_sda_low = ~b;
        tick(Q);
        rise_scl();
        tick(Q);
        m_scl_low = 1'b1;
    endtask

    task automatic recv_bit(output logic b);
        tick(2);
        m_sda_low = 1'b0;
        tick(Q);
        rise_scl();
        tick(Q / 2);
        b = sda_line;
        tick(Q / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic do_start();
        tick(2);
        m_sda_low = 1'b0;
        tick(Q);
        rise_scl();
        tick(Q);
        m_sda_low = 1'b1;
        tick(Q);
        m_scl_low = 1'b1;
    endtask

    task automatic do_stop();
        tick(2);
        m_sda_low = 1'b1;
        tick(Q);
        rise_scl();
        tick(Q);
        m_sda_low = 1'b0;
        tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            b[i] = x;
        end
        send_bit(~ack);
    endtask

    task automatic check_idle(input string tag);
        tick(4);
        check(!sda_oe && !scl_oe && busy_n && !wr_valid && !rd_req, tag,
              {27'd0, sda_oe, scl_oe, busy_n, wr_valid, rd_req}, 32'h4);
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        logic [31:0] word, got;
        logic [39:0] v;
        int c0, d0, f0;

        tick(5);
        check_idle("R1 reset");
        rst_n = 1'b1;
        tick(5);
        check_idle("R1 after release");

        // vector walk
        for (int i = 0; i < 6; i++) begin
            v = VECS[i];
            word = v[31:0];
            stretched = 1'b0;
            stretch_busy = 1'b1;
            if (v[39]) rd_queue[nfetch % 8] = word;
            do_start();
            write_byte({v[38:32], v[39]}, ack);
            if (v[38:32] != ADDR) begin
                check(!ack, "R2 mismatch nack", {31'd0, ack}, 32'd0);
                d0 = drive_cnt;
                write_byte(word[31:24], ack);
                check(!ack && drive_cnt == d0, "R2 no drive after mismatch", drive_cnt, d0);
            end else if (!v[39]) begin
                check(ack, "R2 address ack", {31'd0, ack}, 32'd1);
                c0 = ncap;
                for (int k = 3; k >= 0; k--) begin
                    write_byte(word[k*8 +: 8], ack);
                    check(ack, "R3 byte ack", {31'd0, ack}, 32'd1);
                end
                do_stop();
                check(ncap == c0 + 1, "R3 word count", ncap, c0 + 1);
                check(cap[c0 % 8] == word, "R3 word value", cap[c0 % 8], word);
                check(stretched && !stretch_busy, "R4 stretch with busy low",
                      {30'd0, stretched, stretch_busy}, 32'h2);
            end else begin
                check(ack, "R2 address ack", {31'd0, ack}, 32'd1);
                for (int k = 3; k >= 0; k--) begin
                    read_byte(b, k != 0);
                    got[k*8 +: 8] = b;
                end
                check(got == word, "R5 read word", got, word);
                check(stretched && !stretch_busy, "R5 fetch stretch with busy low",
                      {30'd0, stretched, stretch_busy}, 32'h2);
            end
            if (v[38:32] != ADDR || v[39]) do_stop();
            check_idle("R1 after stop");
        end

        // R9 and R10: ack release, two write words in one transfer
        do_start();
        write_byte({ADDR, 1'b0}, ack);
        tick(8);
        check(!sda_oe, "R9 ack released", {31'd0, sda_oe}, 32'd0);
        c0 = ncap;
        for (int k = 0; k < 8; k++) write_byte(8'h10 + 8'(k), ack);
        do_stop();
        check(ncap == c0 + 2, "R10 two words written", ncap, c0 + 2);
        check(cap[c0 % 8] == 32'h10111213, "R10 first word", cap[c0 % 8], 32'h10111213);
        check(cap[(c0 + 1) % 8] == 32'h14151617, "R10 second word", cap[(c0 + 1) % 8], 32'h14151617);

        // R10: two read words in one transfer
        rd_queue[nfetch % 8] = 32'hCAFE0123;
        rd_queue[(nfetch + 1) % 8] = 32'h4567BABE;
        do_start();
        write_byte({ADDR, 1'b1}, ack);
        for (int k = 7; k >= 0; k--) begin
            read_byte(b, k != 0);
            if (k >= 4) got[(k-4)*8 +: 8] = b;
            if (k == 4) check(got == 32'hCAFE0123, "R10 first read word", got, 32'hCAFE0123);
            if (k < 4) got[k*8 +: 8] = b;
        end
        check(got == 32'h4567BABE, "R10 second read word", got, 32'h4567BABE);
        do_stop();

        // R7: host NACK in mid-word
        rd_queue[nfetch % 8] = 32'h00000000;
        do_start();
        write_byte({ADDR, 1'b1}, ack);
        read_byte(b, 1'b0);
        tick(6);
        d0 = drive_cnt;
        f0 = nfetch;
        for (int k = 0; k < 9; k++) recv_bit(ack);
        check(drive_cnt == d0, "R7 no drive after nack", drive_cnt, d0);
        check(nfetch == f0 && !rd_req, "R7 no fetch after nack", nfetch, f0);
        do_stop();

        // R8: repeated start drops partial write word
        c0 = ncap;
        rd_queue[nfetch % 8] = 32'h5A5AC3C3;
        do_start();
        write_byte({ADDR, 1'b0}, ack);
        write_byte(8'hEE, ack);
        write_byte(8'hDD, ack);
        do_start();
        write_byte({ADDR, 1'b1}, ack);
        check(ack, "R8 repeated start address ack", {31'd0, ack}, 32'd1);
        for (int k = 3; k >= 0; k--) begin
            read_byte(b, k != 0);
            got[k*8 +: 8] = b;
        end
        check(got == 32'h5A5AC3C3, "R8 read after repeated start", got, 32'h5A5AC3C3);
        do_stop();
        check(ncap == c0, "R8 partial word discarded", ncap, c0);

        check(glitch == 0, "R6 sda steady while scl high", glitch, 0);
        finish_run();
    end

endmodule